// File: doc/BRIEF.md
# Coherence Packet Handler for a Write-Through L1 Cache

This block is the coherence side of a write-through first-level cache. It has a target port that takes write packets from the memory controller and sorts them by the register word they address. An update packet names a cache line, then a starting word position, then any number of data words. Those words are written into consecutive word slots of the line, but only if the line is resident. An invalidation packet is a single word naming a line, and that line is dropped if present. Each packet is answered with one response word after its final word. The error flag in that word is raised for an unknown register, a truncated update, or a data word that falls past the end of the line.

The cache arrays are seen through a small request interface. A combinational presence probe looks up a line index. A word-write strobe carries line, word position and data. An invalidate strobe carries a line index. Because the cache is write-through, a line that is updated or invalidated never holds dirty data, so nothing has to be written back.

The block also owns the outbound cleanup message. When the replacement logic discards a line after a miss, it offers that line index on the eviction input. A one-entry buffer turns it into a one-word cleanup packet toward the memory controller and holds it until the packet is taken. A coherence packet whose line equals the line being filled is held at its first word until the fill ends. This keeps the fill from overwriting the effect of the coherence packet.

Top module: `coh_handler`

## Requirements
- R1: After reset, rspValid and cleanupValid are 0, and evictReady and tgtReady are 1.
- R2: An invalidation packet uses register code 1, and its first word carries the line index in its low bits. If that line is present, invEn pulses with invLine equal to the index in the cycle that first word is accepted.
- R3: An invalidation of a line that is not present causes no invEn pulse and gets a response with rspErr 0.
- R4: An update packet uses register code 0. Its words are, in order: the line index, the start offset, and N data words. When the line is present, data word k is written with wordWrEn to word position offset+k of that line.
- R5: An update of a line that is not present performs no word write and gets a response with rspErr 0, unless R6 applies.
- R6: A data word whose position offset+k is at least WORDS is not written, and the packet's response has rspErr 1. Data words at earlier positions are still written. An update with N=0 is not an error, whatever its offset.
- R7: A packet to register code 2 or 3 has all of its words accepted. It causes no invalidation and no word write, and its response has rspErr 1.
- R8: Every packet gets exactly one response: rspValid is 1 for one cycle, in the cycle after its last word (tgtLast) is accepted.
- R9: While fillBusy is 1, the first word of an update or invalidation packet whose line equals fillLine is held with tgtReady 0. It is accepted once fillBusy falls. A packet for a different line is not held.
- R10: An eviction offered while the cleanup buffer is empty is accepted. From the next cycle, cleanupValid is 1 with cleanupData equal to the evicted line index, and it holds until cleanupReady is seen. While a cleanup is pending, evictReady is 0.
- R11: An update packet that ends on its line-index word performs no write and gets a response with rspErr 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tgtValid | input | 1 | Incoming coherence word valid |
| tgtReady | output | 1 | Incoming word accepted this cycle |
| tgtReg | input | REG_W | Register code addressed by the packet |
| tgtData | input | DATA_W | Incoming packet word |
| tgtLast | input | 1 | Marks the final word of a packet |
| rspValid | output | 1 | One-cycle response for a finished packet |
| rspErr | output | 1 | Error flag of the response |
| probeLine | output | LINE_W | Line index looked up in the tag array |
| probeHit | input | 1 | Tag array reports probeLine as present |
| wordWrEn | output | 1 | Write one data word into the cache |
| wordWrLine | output | LINE_W | Line of the word write |
| wordWrIdx | output | OFF_W | Word position of the word write |
| wordWrData | output | DATA_W | Data of the word write |
| invEn | output | 1 | Invalidate one line |
| invLine | output | LINE_W | Line to invalidate |
| fillBusy | input | 1 | A line fill is in progress |
| fillLine | input | LINE_W | Line being filled |
| evictValid | input | 1 | Replacement offers a discarded line |
| evictLine | input | LINE_W | Index of the discarded line |
| evictReady | output | 1 | Eviction accepted this cycle |
| cleanupValid | output | 1 | Cleanup packet word pending |
| cleanupData | output | DATA_W | Cleanup word: discarded line index |
| cleanupReady | input | 1 | Memory side takes the cleanup word |

## Verification
An eviction can be accepted into the cleanup buffer in the same cycle that an update data word is written into the cache. These two paths share the datapath registers, so the bench offers an eviction at the exact cycle of the first data word of an update. It then checks that the cleanup word carries the evicted index and that the cache received both data words at the right positions. The release of a held packet at the end of a fill is checked the same way. The bench samples tgtReady while fillBusy is high and counts invalidations on both sides of the release.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    ST_HEAD,
    ST_OFFSET,
    ST_DATA,
    ST_DRAIN
  } cohState_e;

  // Strobes from control to datapath, valid for one accepted word
  typedef struct packed {
    logic capLine;
    logic capOffset;
    logic writeWord;
    logic doInval;
    logic setErr;
    logic respond;
  } cohStrobe_t;

endpackage

// File: rtl/coh_ctrl.sv
module coh_ctrl
  import coh_pkg::*;
#(
  parameter int REG_W    = 2,
  parameter int UPD_CODE = 0,
  parameter int INV_CODE = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tgtValid,
  input  logic             tgtLast,
  input  logic [REG_W-1:0] tgtReg,
  input  logic             fillConflict,
  output logic             tgtReady,
  output logic             atHead,
  output cohStrobe_t       strobe
);

  cohState_e state, nextState;
  logic isUpd, isInv, accept;

  assign isUpd  = (tgtReg == REG_W'(UPD_CODE));
  assign isInv  = (tgtReg == REG_W'(INV_CODE));
  assign atHead = (state == ST_HEAD);

  // Only a known packet header can conflict with a fill
  assign tgtReady = !(atHead && (isUpd || isInv) && fillConflict);
  assign accept   = tgtValid && tgtReady;

  always_comb begin
    strobe    = '0;
    nextState = state;
    if (accept) begin
      unique case (state)
        ST_HEAD: begin
          if (isUpd) begin
            strobe.capLine = 1'b1;
            if (tgtLast) strobe.setErr = 1'b1;
            else         nextState     = ST_OFFSET;
          end else if (isInv) begin
            strobe.doInval = 1'b1;
            if (!tgtLast) nextState = ST_DRAIN;
          end else begin
            strobe.setErr = 1'b1;
            if (!tgtLast) nextState = ST_DRAIN;
          end
        end
        ST_OFFSET: begin
          strobe.capOffset = 1'b1;
          if (!tgtLast) nextState = ST_DATA;
        end
        ST_DATA:  strobe.writeWord = 1'b1;
        ST_DRAIN: ;
        default:  ;
      endcase
      if (tgtLast) begin
        strobe.respond = 1'b1;
        nextState      = ST_HEAD;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_HEAD;
    else       state <= nextState;
  end

endmodule

// File: rtl/coh_dp.sv
module coh_dp
  import coh_pkg::*;
#(
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int LINE_W = 4,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  cohStrobe_t        strobe,
  input  logic [DATA_W-1:0] tgtData,
  input  logic              probeHit,
  input  logic              fillBusy,
  input  logic [LINE_W-1:0] fillLine,
  output logic              fillConflict,
  output logic [LINE_W-1:0] probeLine,
  output logic              wordWrEn,
  output logic [LINE_W-1:0] wordWrLine,
  output logic [OFF_W-1:0]  wordWrIdx,
  output logic [DATA_W-1:0] wordWrData,
  output logic              invEn,
  output logic [LINE_W-1:0] invLine,
  output logic              rspValid,
  output logic              rspErr,
  input  logic              evictValid,
  input  logic [LINE_W-1:0] evictLine,
  output logic              evictReady,
  output logic              cleanupValid,
  output logic [DATA_W-1:0] cleanupData,
  input  logic              cleanupReady
);

  logic [LINE_W-1:0] lineReg;
  logic              hitReg;
  logic [OFF_W-1:0]  wordPtr;
  logic              pastEnd;
  logic              errReg, errNext;
  logic [LINE_W-1:0] headLine;

  assign headLine     = tgtData[LINE_W-1:0];
  assign probeLine    = headLine;
  assign fillConflict = fillBusy && (fillLine == headLine);

  assign invEn   = strobe.doInval && probeHit;
  assign invLine = headLine;

  assign wordWrEn   = strobe.writeWord && hitReg && !pastEnd;
  assign wordWrLine = lineReg;
  assign wordWrIdx  = wordPtr;
  assign wordWrData = tgtData;

  assign errNext = errReg || strobe.setErr || (strobe.writeWord && pastEnd);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineReg  <= '0;
      hitReg   <= 1'b0;
      wordPtr  <= '0;
      pastEnd  <= 1'b0;
      errReg   <= 1'b0;
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      if (strobe.capLine) begin
        lineReg <= headLine;
        hitReg  <= probeHit;
      end
      if (strobe.capOffset) begin
        wordPtr <= tgtData[OFF_W-1:0];
        pastEnd <= |tgtData[DATA_W-1:OFF_W];
      end else if (strobe.writeWord) begin
        wordPtr <= OFF_W'(wordPtr + 1'b1);
        if (wordPtr == OFF_W'(WORDS - 1)) pastEnd <= 1'b1;
      end
      rspValid <= strobe.respond;
      rspErr   <= strobe.respond && errNext;
      errReg   <= strobe.respond ? 1'b0 : errNext;
    end
  end

  // One-entry cleanup buffer toward the memory controller
  assign evictReady = !cleanupValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cleanupValid <= 1'b0;
      cleanupData  <= '0;
    end else if (cleanupValid) begin
      if (cleanupReady) cleanupValid <= 1'b0;
    end else if (evictValid) begin
      cleanupValid <= 1'b1;
      cleanupData  <= DATA_W'(evictLine);
    end
  end

endmodule

// File: rtl/coh_handler.sv
module coh_handler
  import coh_pkg::*;
#(
  parameter int LINES    = 16,
  parameter int WORDS    = 4,
  parameter int DATA_W   = 32,
  parameter int REG_W    = 2,
  parameter int UPD_CODE = 0,
  parameter int INV_CODE = 1,
  localparam int LINE_W  = $clog2(LINES),
  localparam int OFF_W   = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tgtValid,
  output logic              tgtReady,
  input  logic [REG_W-1:0]  tgtReg,
  input  logic [DATA_W-1:0] tgtData,
  input  logic              tgtLast,
  output logic              rspValid,
  output logic              rspErr,
  output logic [LINE_W-1:0] probeLine,
  input  logic              probeHit,
  output logic              wordWrEn,
  output logic [LINE_W-1:0] wordWrLine,
  output logic [OFF_W-1:0]  wordWrIdx,
  output logic [DATA_W-1:0] wordWrData,
  output logic              invEn,
  output logic [LINE_W-1:0] invLine,
  input  logic              fillBusy,
  input  logic [LINE_W-1:0] fillLine,
  input  logic              evictValid,
  input  logic [LINE_W-1:0] evictLine,
  output logic              evictReady,
  output logic              cleanupValid,
  output logic [DATA_W-1:0] cleanupData,
  input  logic              cleanupReady
);

  cohStrobe_t strobe;
  logic       fillConflict;
  logic       atHead;

  coh_ctrl #(
    .REG_W(REG_W), .UPD_CODE(UPD_CODE), .INV_CODE(INV_CODE)
  ) ctrl (
    .clk(clk), .rstN(rstN), .tgtValid(tgtValid), .tgtLast(tgtLast),
    .tgtReg(tgtReg), .fillConflict(fillConflict), .tgtReady(tgtReady),
    .atHead(atHead), .strobe(strobe)
  );

  coh_dp #(
    .WORDS(WORDS), .DATA_W(DATA_W), .LINE_W(LINE_W), .OFF_W(OFF_W)
  ) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tgtData(tgtData),
    .probeHit(probeHit), .fillBusy(fillBusy), .fillLine(fillLine),
    .fillConflict(fillConflict), .probeLine(probeLine),
    .wordWrEn(wordWrEn), .wordWrLine(wordWrLine), .wordWrIdx(wordWrIdx),
    .wordWrData(wordWrData), .invEn(invEn), .invLine(invLine),
    .rspValid(rspValid), .rspErr(rspErr), .evictValid(evictValid),
    .evictLine(evictLine), .evictReady(evictReady),
    .cleanupValid(cleanupValid), .cleanupData(cleanupData),
    .cleanupReady(cleanupReady)
  );

endmodule

// File: rtl/coh_handler_chk.sv
module coh_handler_chk #(
  parameter int DATA_W   = 32,
  parameter int REG_W    = 2,
  parameter int LINE_W   = 4,
  parameter int INV_CODE = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              tgtValid,
  input logic              tgtReady,
  input logic [REG_W-1:0]  tgtReg,
  input logic              tgtLast,
  input logic              atHead,
  input logic              rspValid,
  input logic              wordWrEn,
  input logic              invEn,
  input logic [LINE_W-1:0] invLine,
  input logic              fillBusy,
  input logic [LINE_W-1:0] fillLine,
  input logic              evictReady,
  input logic              cleanupValid,
  input logic [DATA_W-1:0] cleanupData,
  input logic              cleanupReady
);

  // R8: a response only follows an accepted last word
  p_rsp_after_last_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(tgtValid && tgtReady && tgtLast));

  // R2: invalidation only on an accepted invalidation header
  p_inv_on_header_r2: assert property (@(posedge clk) disable iff (!rstN)
    invEn |-> (tgtValid && tgtReady && atHead && tgtReg == REG_W'(INV_CODE)));

  // R9: never invalidate the line under fill
  p_no_inv_in_fill_r9: assert property (@(posedge clk) disable iff (!rstN)
    invEn |-> !(fillBusy && fillLine == invLine));

  // R4: word writes only on accepted data words
  p_write_on_accept_r4: assert property (@(posedge clk) disable iff (!rstN)
    wordWrEn |-> (tgtValid && tgtReady && !atHead));

  // R10: pending cleanup holds its word
  p_cleanup_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cleanupValid && !cleanupReady) |=> (cleanupValid && $stable(cleanupData)));

  // R10: no eviction taken while one is pending
  p_evict_block_r10: assert property (@(posedge clk) disable iff (!rstN)
    cleanupValid |-> !evictReady);

endmodule

bind coh_handler coh_handler_chk #(
  .DATA_W(DATA_W), .REG_W(REG_W), .LINE_W(LINE_W), .INV_CODE(INV_CODE)
) chk (
  .clk(clk), .rstN(rstN), .tgtValid(tgtValid), .tgtReady(tgtReady),
  .tgtReg(tgtReg), .tgtLast(tgtLast), .atHead(atHead), .rspValid(rspValid),
  .wordWrEn(wordWrEn), .invEn(invEn), .invLine(invLine),
  .fillBusy(fillBusy), .fillLine(fillLine), .evictReady(evictReady),
  .cleanupValid(cleanupValid), .cleanupData(cleanupData),
  .cleanupReady(cleanupReady)
);

// File: tb/coh_handler_test.sv
`timescale 1ns/1ps
module coh_handler_test;

  localparam int LINES = 16, WORDS = 4, DW = 32, LW = 4, OW = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic tgtValid = 0, tgtLast = 0, tgtReady;
  logic [1:0] tgtReg = 0;
  logic [DW-1:0] tgtData = 0;
  logic rspValid, rspErr;
  logic [LW-1:0] probeLine, wordWrLine, invLine, fillLine = 0, evictLine = 0;
  logic probeHit, wordWrEn, invEn, fillBusy = 0, evictValid = 0, evictReady;
  logic [OW-1:0] wordWrIdx;
  logic [DW-1:0] wordWrData, cleanupData;
  logic cleanupValid, cleanupReady = 0;

  logic [LINES-1:0] present = '0;
  logic [DW-1:0] shadow [LINES*WORDS];
  int writeCount = 0, invCount = 0, rspCount = 0;
  logic lastErr = 0;
  logic [LW-1:0] lastInvLine = 0;
  int nChecks = 0, nErr = 0;

  assign probeHit = present[probeLine];

  always #4 clk = ~clk;

  coh_handler uut (
    .clk(clk), .rstN(rstN), .tgtValid(tgtValid), .tgtReady(tgtReady),
    .tgtReg(tgtReg), .tgtData(tgtData), .tgtLast(tgtLast),
    .rspValid(rspValid), .rspErr(rspErr), .probeLine(probeLine),
    .probeHit(probeHit), .wordWrEn(wordWrEn), .wordWrLine(wordWrLine),
    .wordWrIdx(wordWrIdx), .wordWrData(wordWrData), .invEn(invEn),
    .invLine(invLine), .fillBusy(fillBusy), .fillLine(fillLine),
    .evictValid(evictValid), .evictLine(evictLine), .evictReady(evictReady),
    .cleanupValid(cleanupValid), .cleanupData(cleanupData),
    .cleanupReady(cleanupReady)
  );

  always @(posedge clk) begin
    if (wordWrEn) begin
      shadow[int'(wordWrLine) * WORDS + int'(wordWrIdx)] = wordWrData;
      writeCount++;
    end
    if (invEn) begin
      invCount++;
      lastInvLine = invLine;
    end
    if (rspValid) begin
      rspCount++;
      lastErr = rspErr;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendWord(input logic [1:0] r, input logic [DW-1:0] d, input bit last);
    @(negedge clk);
    tgtValid = 1'b1; tgtReg = r; tgtData = d; tgtLast = last;
    while (!tgtReady) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic endPacket();
    @(negedge clk);
    tgtValid = 1'b0; tgtLast = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [DW-1:0] dataOf(input int line, input int off, input int k);
    return DW'(line * 256 + off * 16 + k + 1);
  endfunction

  task automatic clearShadow();
    for (int i = 0; i < LINES * WORDS; i++) shadow[i] = '0;
  endtask

  // R4 R5 R6: one update case with arithmetic expectations
  task automatic runUpdate(input int line, input int off, input int n, input bit hit);
    int w0, r0, expWrites;
    bit expErr;
    present[line] = hit;
    clearShadow();
    w0 = writeCount; r0 = rspCount;
    sendWord(2'd0, DW'(line), 1'b0);
    sendWord(2'd0, DW'(off), n == 0);
    for (int k = 0; k < n; k++) sendWord(2'd0, dataOf(line, off, k), k == n - 1);
    endPacket();
    expWrites = 0;
    for (int k = 0; k < n; k++) if (hit && off + k < WORDS) expWrites++;
    expErr = (n > 0) && (off + n > WORDS);
    for (int w = 0; w < WORDS; w++) begin
      logic [DW-1:0] e;
      e = (hit && w >= off && w < off + n) ? dataOf(line, off, w - off) : '0;
      check(shadow[line * WORDS + w] == e, hit ? "R4 word content" : "R5 absent no write",
            int'(shadow[line * WORDS + w]), int'(e));
    end
    check(writeCount - w0 == expWrites, "R6 write count", writeCount - w0, expWrites);
    check(rspCount - r0 == 1, "R8 one response", rspCount - r0, 1);
    check(lastErr == expErr, "R6 error flag", int'(lastErr), int'(expErr));
  endtask

  initial begin
    int r0, i0, w0;
    repeat (3) @(negedge clk);
    check(rspValid == 0 && cleanupValid == 0, "R1 reset outputs", int'(rspValid | cleanupValid), 0);
    check(evictReady == 1 && tgtReady == 1, "R1 reset ready", int'(evictReady & tgtReady), 1);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3: invalidate sweep across lines, odd lines present
    for (int l = 0; l < LINES; l++) begin
      present[l] = l[0];
      i0 = invCount; r0 = rspCount;
      sendWord(2'd1, DW'(l), 1'b1);
      endPacket();
      check(invCount - i0 == int'(l[0]), l[0] ? "R2 invalidate hit" : "R3 invalidate miss",
            invCount - i0, int'(l[0]));
      if (l[0]) check(lastInvLine == LW'(l), "R2 invalidate line", int'(lastInvLine), l);
      check(rspCount - r0 == 1 && lastErr == 0, "R3 response ok", int'(lastErr), 0);
    end

    // R4 R5 R6: offsets 0..WORDS, N 0..WORDS+1, present and absent
    for (int h = 0; h < 2; h++)
      for (int off = 0; off <= WORDS; off++)
        for (int n = 0; n <= WORDS + 1; n++)
          runUpdate((off * 6 + n) % LINES, off, n, h[0]);

    // R11: truncated update
    present[3] = 1'b1; w0 = writeCount; r0 = rspCount;
    sendWord(2'd0, DW'(3), 1'b1);
    endPacket();
    check(writeCount == w0, "R11 no write", writeCount - w0, 0);
    check(rspCount - r0 == 1 && lastErr == 1, "R11 error response", int'(lastErr), 1);

    // R7: unknown registers, one and three word packets
    for (int r = 2; r < 4; r++)
      for (int len = 1; len <= 3; len += 2) begin
        present[5] = 1'b1; w0 = writeCount; i0 = invCount; r0 = rspCount;
        for (int k = 0; k < len; k++) sendWord(2'(r), DW'(5), k == len - 1);
        endPacket();
        check(writeCount == w0 && invCount == i0, "R7 no cache effect",
              writeCount - w0 + invCount - i0, 0);
        check(rspCount - r0 == 1, "R7 one response", rspCount - r0, 1);
        check(lastErr == 1, "R7 error flag", int'(lastErr), 1);
      end

    // R9: hold against a fill of the same line
    present[5] = 1'b1; fillBusy = 1'b1; fillLine = 4'd5; i0 = invCount;
    @(negedge clk);
    tgtValid = 1'b1; tgtReg = 2'd1; tgtData = DW'(5); tgtLast = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check(tgtReady == 0, "R9 held during fill", int'(tgtReady), 0);
    end
    check(invCount == i0, "R9 no invalidate while held", invCount - i0, 0);
    fillBusy = 1'b0;
    @(posedge clk);
    endPacket();
    check(invCount - i0 == 1, "R9 released after fill", invCount - i0, 1);
    fillBusy = 1'b1; fillLine = 4'd6;
    @(negedge clk);
    tgtValid = 1'b1; tgtReg = 2'd1; tgtData = DW'(5); tgtLast = 1'b1;
    #1;
    check(tgtReady == 1, "R9 other line not held", int'(tgtReady), 1);
    @(posedge clk);
    endPacket();
    fillBusy = 1'b0;

    // R10: cleanup buffer
    evictValid = 1'b1; evictLine = 4'd9;
    check(evictReady == 1, "R10 evict accepted", int'(evictReady), 1);
    @(negedge clk);
    evictLine = 4'd3;
    for (int c = 0; c < 3; c++) begin
      check(cleanupValid == 1 && cleanupData == 9, "R10 cleanup word", int'(cleanupData), 9);
      check(evictReady == 0, "R10 evict blocked", int'(evictReady), 0);
      @(negedge clk);
    end
    cleanupReady = 1'b1;
    @(negedge clk);
    cleanupReady = 1'b0;
    check(cleanupValid == 0 && evictReady == 1, "R10 drained", int'(cleanupValid), 0);
    @(negedge clk);
    evictValid = 1'b0;
    check(cleanupValid == 1 && cleanupData == 3, "R10 second cleanup", int'(cleanupData), 3);
    cleanupReady = 1'b1;
    @(negedge clk);
    cleanupReady = 1'b0;

    // R4 R10: eviction in the same cycle as an update data word
    present[2] = 1'b1; clearShadow();
    sendWord(2'd0, DW'(2), 1'b0);
    sendWord(2'd0, DW'(0), 1'b0);
    @(negedge clk);
    tgtData = dataOf(2, 0, 0); tgtLast = 1'b0; evictValid = 1'b1; evictLine = 4'd7;
    @(posedge clk);
    @(negedge clk);
    evictValid = 1'b0; tgtData = dataOf(2, 0, 1); tgtLast = 1'b1;
    @(posedge clk);
    endPacket();
    check(cleanupValid == 1 && cleanupData == 7, "R10 concurrent cleanup", int'(cleanupData), 7);
    check(shadow[8] == dataOf(2, 0, 0), "R4 concurrent word 0", int'(shadow[8]), int'(dataOf(2, 0, 0)));
    check(shadow[9] == dataOf(2, 0, 1), "R4 concurrent word 1", int'(shadow[9]), int'(dataOf(2, 0, 1)));
    cleanupReady = 1'b1;
    @(negedge clk);
    cleanupReady = 1'b0;

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule